// File: doc/BRIEF.md
# Queued Sector Erase Scheduler with Suspend

This block sequences sector erasure for a flash-style storage array. A decoder upstream turns bus writes into single-cycle command flags, each qualified by a write strobe. The first sector-erase request opens a collection window. While the window is open, further requests add sectors to a bitmap, and every write strobe restarts the window timer. When the timer runs out, the scheduler drops protected sectors from the set. It then erases the rest one at a time, lowest sector number first, spending a fixed number of clock cycles on each.

A suspend request pauses the work, whether it arrives during the window or during an erase. Suspend can be issued and undone with resume any number of times. A resumed erase continues with the time that was left for the current sector. All durations are parameters given in clock cycles. The array contents and the analog erase pulses belong to other blocks.

Command flags count only in a cycle where `wr_stb` is high. If several flags are high together, priority runs from highest to lowest as follows: erase request, suspend, resume, other.

Top module: `erase_sched`

## Requirements
- R1: After reset, `busy`, `window_open`, `suspended` and `done` are low and `pend_map` is zero.
- R2: In idle, a sector-erase request for sector s makes `window_open` high and sets bit s of `pend_map` on the next cycle. With no further strobe, the window stays open for exactly WINDOW_CYC cycles and erasing then begins.
- R3: While the window is open, each further sector-erase request sets its sector's bit. Any write strobe, with or without a command, reloads the timer, so the window closes WINDOW_CYC cycles after the last strobe. No bit is lost while the window stays open.
- R4: A resume or other command while the window is open clears `pend_map` and returns the block to idle. No busy cycle and no `done` pulse follow.
- R5: A suspend while the window is open closes the window on the next cycle. `suspended` goes high and `busy` stays low.
- R6: When the window closes, bits of sectors flagged in `protect` are removed. If none remain, `busy` stays high for exactly PROT_CYC cycles and then `done` pulses, with `pend_map` zero.
- R7: Queued sectors are erased in ascending number order. Each sector takes ERASE_CYC busy cycles, after which its bit clears. `pend_map` never gains bits while busy. After the last sector, `done` pulses for one cycle, with `busy` low and `pend_map` zero.
- R8: A suspend during erasing raises `suspended` SUSP_LAT cycles later. Erasing continues during that latency, and a repeated suspend neither restarts nor extends it.
- R9: While suspended, `pend_map` and the suspended state hold until a resume arrives. Resume continues the current sector with its remaining time, so every sector still totals ERASE_CYC busy cycles however often it is suspended. Repeated resumes are ignored.
- R10: Commands other than suspend are ignored while erasing. In idle, every command except a sector-erase request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe; qualifies command flags and restarts the window |
| cmd_erase | input | 1 | Sector-erase request |
| cmd_sector | input | $clog2(NSEC) | Sector number for the erase request |
| cmd_suspend | input | 1 | Erase suspend |
| cmd_resume | input | 1 | Erase resume |
| cmd_other | input | 1 | Any other decoded command |
| protect | input | NSEC | Per-sector protection flags |
| busy | output | 1 | Erasing, suspend latency, or protected-only busy period |
| pend_map | output | NSEC | Sectors still to be erased |
| window_open | output | 1 | Collection window open |
| suspended | output | 1 | Erase suspended |
| done | output | 1 | One-cycle pulse when the scheduled work ends |

## Verification
The assertions check these properties on every cycle:
- The bitmap only grows while the window is open and only shrinks while busy.
- No protected sector survives the window closing.
- The suspended state and bitmap stay frozen until a resume.
- `done` only appears with an empty bitmap.
- Idle ignores everything except an erase request.

Only the directed scenarios can show the following:
- The exact window length after restarts.
- The ascending erase order.
- The suspend latency.
- The fact that total busy time per sector survives repeated suspend and resume.

// File: rtl/erase_sched.sv
module erase_sched #(
  parameter int NSEC       = 8,
  parameter int WINDOW_CYC = 16,
  parameter int ERASE_CYC  = 20,
  parameter int SUSP_LAT   = 3,
  parameter int PROT_CYC   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic                    cmd_erase,
  input  logic [$clog2(NSEC)-1:0] cmd_sector,
  input  logic                    cmd_suspend,
  input  logic                    cmd_resume,
  input  logic                    cmd_other,
  input  logic [NSEC-1:0]         protect,
  output logic                    busy,
  output logic [NSEC-1:0]         pend_map,
  output logic                    window_open,
  output logic                    suspended,
  output logic                    done
);
  localparam int SW   = $clog2(NSEC);
  localparam int TMAX = (WINDOW_CYC > SUSP_LAT) ?
                        ((WINDOW_CYC > PROT_CYC) ? WINDOW_CYC : PROT_CYC) :
                        ((SUSP_LAT > PROT_CYC) ? SUSP_LAT : PROT_CYC);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int EW   = $clog2(ERASE_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WIN, S_ERASE, S_SWAIT, S_SUSP, S_PROT} st_t;

  st_t            st;
  logic [TW-1:0]  tcnt;
  logic [EW-1:0]  ecnt;
  logic [NSEC-1:0] map;

  logic            go_erase, go_susp, go_res, go_other;
  logic [NSEC-1:0] req_bit, live, after_one;
  logic            sect_end, last_end;

  assign go_erase  = wr_stb && cmd_erase;
  assign go_susp   = wr_stb && !cmd_erase && cmd_suspend;
  assign go_res    = wr_stb && !cmd_erase && !cmd_suspend && cmd_resume;
  assign go_other  = wr_stb && !cmd_erase && !cmd_suspend && !cmd_resume && cmd_other;
  assign req_bit   = {{(NSEC-1){1'b0}}, 1'b1} << cmd_sector;
  assign live      = map & ~protect;
  assign after_one = map & (map - 1'b1);
  assign sect_end  = (ecnt == EW'(1));
  assign last_end  = sect_end && (after_one == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      ecnt <= '0;
      map  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go_erase) begin
            map  <= req_bit;
            tcnt <= TW'(WINDOW_CYC);
            st   <= S_WIN;
          end
        end
        S_WIN: begin
          if (go_erase) begin
            map  <= map | req_bit;
            tcnt <= TW'(WINDOW_CYC);
          end else if (go_susp) begin
            map  <= live;
            ecnt <= EW'(ERASE_CYC);
            st   <= S_SUSP;
          end else if (go_res || go_other) begin
            map <= '0;
            st  <= S_IDLE;
          end else if (wr_stb) begin
            tcnt <= TW'(WINDOW_CYC);
          end else if (tcnt == TW'(1)) begin
            map  <= live;
            ecnt <= EW'(ERASE_CYC);
            if (live == '0) begin
              tcnt <= TW'(PROT_CYC);
              st   <= S_PROT;
            end else begin
              st <= S_ERASE;
            end
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        S_ERASE, S_SWAIT: begin
          if (sect_end) begin
            map  <= after_one;
            ecnt <= EW'(ERASE_CYC);
          end else begin
            ecnt <= ecnt - 1'b1;
          end
          if (last_end) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else if (st == S_ERASE) begin
            if (go_susp) begin
              tcnt <= TW'(SUSP_LAT);
              st   <= S_SWAIT;
            end
          end else if (tcnt == TW'(1)) begin
            st <= S_SUSP;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        S_SUSP: begin
          if (go_res) begin
            if (map == '0) begin
              tcnt <= TW'(PROT_CYC);
              st   <= S_PROT;
            end else begin
              st <= S_ERASE;
            end
          end
        end
        S_PROT: begin
          if (tcnt == TW'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st == S_ERASE) || (st == S_SWAIT) || (st == S_PROT);
  assign window_open = (st == S_WIN);
  assign suspended   = (st == S_SUSP);
  assign pend_map    = map;

  AST_WIN_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (window_open && $past(window_open)) |-> (($past(pend_map) & ~pend_map) == '0)); // R3
  AST_BUSY_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ((pend_map & ~$past(pend_map)) == '0)); // R7
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend_map == '0 && !busy && !window_open && !suspended)); // R7
  AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_open) |-> ((pend_map & $past(protect)) == '0)); // R6
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !(wr_stb && cmd_resume && !cmd_erase && !cmd_suspend))
      |=> (suspended && $stable(pend_map))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !window_open && !suspended && !(wr_stb && cmd_erase))
      |=> (!busy && !window_open && !suspended)); // R10
endmodule

// File: tb/erase_sched_test.sv
module erase_sched_test;
  localparam int NSEC = 8;
  localparam int WIN  = 16;
  localparam int ER   = 20;
  localparam int LAT  = 3;
  localparam int PRT  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, cmd_erase = 1'b0, cmd_suspend = 1'b0, cmd_resume = 1'b0, cmd_other = 1'b0;
  logic [2:0] cmd_sector = '0;
  logic [NSEC-1:0] protect = '0;
  logic busy, window_open, suspended, done;
  logic [NSEC-1:0] pend_map;

  int checks = 0, fails = 0;
  int busy_cnt = 0, win_cnt = 0, done_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  erase_sched #(.NSEC(NSEC), .WINDOW_CYC(WIN), .ERASE_CYC(ER), .SUSP_LAT(LAT), .PROT_CYC(PRT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd_erase(cmd_erase), .cmd_sector(cmd_sector),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_other(cmd_other), .protect(protect),
    .busy(busy), .pend_map(pend_map), .window_open(window_open), .suspended(suspended), .done(done));

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (window_open) win_cnt++;
    if (done) done_cnt++;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    busy_cnt = 0; win_cnt = 0; done_cnt = 0;
  endtask

  task automatic issue(input bit e, input int sec, input bit s, input bit r, input bit o);
    wr_stb = 1'b1; cmd_erase = e; cmd_sector = 3'(sec);
    cmd_suspend = s; cmd_resume = r; cmd_other = o;
    tick();
    wr_stb = 1'b0; cmd_erase = 1'b0; cmd_suspend = 1'b0; cmd_resume = 1'b0; cmd_other = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 500 && done_cnt == 0; n++) tick();
    tick();
  endtask

  task automatic wait_busy();
    for (int n = 0; n < 500 && !busy; n++) tick();
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 window", window_open, 0);
    chk("R1 suspended", suspended, 0);
    chk("R1 done", done, 0);
    chk("R1 map", pend_map, 0);
    clr();
    issue(0, 0, 1, 0, 0);
    issue(0, 0, 0, 1, 0);
    issue(0, 0, 0, 0, 1);
    tick();
    chk("R10 idle ignores suspend", suspended, 0);
    chk("R10 idle no busy", busy_cnt + win_cnt, 0);
  endtask

  task automatic t_single();
    clr();
    issue(1, 3, 0, 0, 0);
    chk("R2 window opens", window_open, 1);
    chk("R2 map bit", pend_map, 8'h08);
    wait_done();
    chk("R2 window length", win_cnt, WIN);
    chk("R7 erase length", busy_cnt, ER);
    chk("R7 one done", done_cnt, 1);
    chk("R7 map empty", pend_map, 0);
    chk("R7 busy low", busy, 0);
  endtask

  task automatic t_multi();
    clr();
    issue(1, 5, 0, 0, 0);
    repeat (4) tick();
    issue(1, 1, 0, 0, 0);
    repeat (3) tick();
    issue(0, 0, 0, 0, 0);
    chk("R3 two sectors", pend_map, 8'h22);
    wait_busy();
    issue(1, 7, 0, 0, 0);
    issue(0, 0, 0, 0, 1);
    repeat (ER - 2) tick();
    chk("R7 lowest first", pend_map, 8'h20);
    chk("R10 erase ignored", pend_map[7], 0);
    wait_done();
    chk("R3 restarted window", win_cnt, 9 + WIN);
    chk("R7 two sectors time", busy_cnt, 2 * ER);
    chk("R7 done once", done_cnt, 1);
  endtask

  task automatic t_abort();
    clr();
    issue(1, 2, 0, 0, 0);
    issue(0, 0, 0, 0, 1);
    chk("R4 window closed", window_open, 0);
    chk("R4 map cleared", pend_map, 0);
    issue(1, 6, 0, 0, 0);
    issue(0, 0, 0, 1, 0);
    chk("R4 resume aborts", pend_map, 0);
    repeat (WIN + 5) tick();
    chk("R4 no busy", busy_cnt, 0);
    chk("R4 no done", done_cnt, 0);
  endtask

  task automatic t_protect();
    protect = 8'h10;
    clr();
    issue(1, 4, 0, 0, 0);
    issue(1, 6, 0, 0, 0);
    wait_busy();
    chk("R6 protected dropped", pend_map, 8'h40);
    wait_done();
    chk("R6 only one erased", busy_cnt, ER);
    clr();
    issue(1, 4, 0, 0, 0);
    wait_done();
    chk("R6 short busy", busy_cnt, PRT);
    chk("R6 done", done_cnt, 1);
    chk("R6 map empty", pend_map, 0);
    protect = '0;
  endtask

  task automatic t_susp_win();
    clr();
    issue(1, 2, 0, 0, 0);
    issue(0, 0, 1, 0, 0);
    chk("R5 suspended", suspended, 1);
    chk("R5 window closed", window_open, 0);
    chk("R5 not busy", busy, 0);
    chk("R5 map kept", pend_map, 8'h04);
    repeat (10) tick();
    chk("R9 held", suspended, 1);
    chk("R9 no busy while held", busy_cnt, 0);
    issue(0, 0, 0, 1, 0);
    wait_done();
    chk("R9 full erase after resume", busy_cnt, ER);
  endtask

  task automatic t_susp_erase();
    clr();
    issue(1, 1, 0, 0, 0);
    issue(1, 6, 0, 0, 0);
    wait_busy();
    repeat (4) tick();
    issue(0, 0, 1, 0, 0);
    issue(0, 0, 1, 0, 0);
    repeat (LAT - 2) tick();
    chk("R8 latency not yet", suspended, 0);
    tick();
    chk("R8 suspended after latency", suspended, 1);
    chk("R8 erased during latency", busy_cnt, 5 + LAT);
    issue(1, 7, 0, 0, 0);
    issue(0, 0, 0, 0, 1);
    issue(0, 0, 1, 0, 0);
    repeat (5) tick();
    chk("R9 still suspended", suspended, 1);
    chk("R9 map frozen", pend_map, 8'h42);
    issue(0, 0, 0, 1, 0);
    issue(0, 0, 0, 1, 0);
    chk("R9 resumed", busy, 1);
    repeat (2) tick();
    issue(0, 0, 1, 0, 0);
    for (int n = 0; n < 50 && !suspended; n++) tick();
    chk("R9 second suspend", suspended, 1);
    issue(0, 0, 0, 1, 0);
    wait_done();
    chk("R9 total time preserved", busy_cnt, 2 * ER);
    chk("R9 map empty", pend_map, 0);
    chk("R9 done once", done_cnt, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_multi();
    t_abort();
    t_protect();
    t_susp_win();
    t_susp_erase();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule